// File: doc/BRIEF.md
# Held-Copy Clock Register Window

This block puts eight timekeeping registers at the eight highest byte addresses of a parallel memory space. The host reaches them with the same chip-enable, output-enable and write-enable cycles it uses for ordinary memory bytes. On the other side sits a free-running calendar counter that is outside this block. The counter supplies the current seconds, minutes, hours, weekday, date, month, year and century. It also gives a one-cycle pulse each time it advances by one second.

The host never reads the counter directly. It reads a user copy that refreshes on the counter's second pulse, so a multi-byte value is never seen half updated. Two hold bits sit in the control byte next to the six-bit century field:

- Read-hold freezes the copy so the host can read it at leisure while the counter keeps going.
- Write-hold lets the host write new values into the copy. When write-hold is cleared, a one-cycle load pulse hands those values to the counter.

An oscillator-stop bit and a frequency-test bit are stored in spare bits of the seconds and weekday bytes and drive out to the timebase.

The window offsets are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 control. The control byte holds write-hold in bit 7, read-hold in bit 6 and the century in bits 5:0.

Top module: `rtcw_top`

## Requirements
- R1: An address whose bits above the low three are all ones selects the window, and the low three bits give the offset. `bus_rd_en` is 1 only for a window read, which is `bus_ce_n`=0, `bus_oe_n`=0 and `bus_we_n`=1. At all other times `bus_rdata` is 0. A write outside the window changes no register.
- R2: With both hold bits at 0, every `cnt_tick` copies the counter bytes into the user copy. The new values are readable from the cycle after the tick edge. Seconds bit 7 and weekday bit 6 are masked off in the copy.
- R3: While read-hold (control bit 6) is 1, ticks leave the user copy unchanged.
- R4: While write-hold (control bit 7) is 1, host writes to offsets 0..6 are stored and ticks are ignored. The control write that clears bit 7 is followed, one cycle later, by a one-cycle `load_pulse`. During that pulse `load_time` carries the user copy (byte i at bits 8i+7:8i) and `load_century` carries the century.
- R5: A control write with bit 7 or bit 6 set to 1 leaves the century field unchanged.
- R6: A control write with bits 7:6 = 00 while write-hold is 1 loads the century from data bits 5:0. With write-hold at 0, such a write leaves the century unchanged.
- R7: After read-hold clears, the copy stays as it was until the next tick. At that tick every byte refreshes in the same cycle.
- R8: Writing seconds bit 7 = 1 stops the timebase (`osc_run`=0), and writing it as 0 restarts it. The bit reads back in seconds bit 7.
- R9: Weekday bit 6 is the frequency-test bit and drives `ftest_en`; it reads back as written. While it is 1 and `osc_run` is 1, seconds bit 0 reads as `sq512`. Otherwise seconds bit 0 reads as the stored value.
- R10: After reset, every register reads 0, `osc_run` is 1, and `ftest_en` and `load_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not a window read |
| bus_rd_en | output | 1 | Window read in progress, drive the data bus |
| win_hit | output | 1 | Address falls in the clock window |
| cnt_time | input | 56 | Counter bytes, offset i at bits 8i+7:8i |
| cnt_century | input | 6 | Counter century |
| cnt_tick | input | 1 | One-cycle pulse per counted second |
| sq512 | input | 1 | 512 Hz test square wave |
| load_pulse | output | 1 | One-cycle strobe to load the counter |
| load_time | output | 56 | Values to load, same layout as cnt_time |
| load_century | output | 6 | Century to load |
| osc_run | output | 1 | Timebase enable |
| ftest_en | output | 1 | Frequency-test enable |

## Verification
The bench builds the block with ADDR_W = 5, so the window is addresses 24 to 31 and address 3 is a nearby address outside it. Each counter tick is driven with a distinct seed, so every byte of the copy can be told apart after each refresh. That makes a missed, partial or forbidden refresh show at the ports. The narrow address keeps the decode of the window edge in view, while the register logic is the same as at the default width.

// File: rtl/rtcw_pkg.sv
`timescale 1ns/1ps
package rtcw_pkg;
  localparam int OFF_W      = 3;
  localparam int TIME_BYTES = 7;
  localparam int CENT_W     = 6;

  localparam logic [OFF_W-1:0] OFF_SEC  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_WDAY = 3'd3;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd7;

  localparam int BIT_OSC   = 7;
  localparam int BIT_FTEST = 6;
  localparam int BIT_WHOLD = 7;
  localparam int BIT_RHOLD = 6;

  // Bits of a time byte kept in the user copy (control bits live elsewhere)
  function automatic logic [7:0] keep_mask(input int idx);
    case (idx)
      0:       keep_mask = 8'h7F;
      3:       keep_mask = 8'hBF;
      default: keep_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtcw_decode.sv
`timescale 1ns/1ps
module rtcw_decode
  import rtcw_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off,
  output logic              wr_en,
  output logic              rd_en
);
  assign hit   = &addr[ADDR_W-1:OFF_W];
  assign off   = addr[OFF_W-1:0];
  assign wr_en = !ce_n && !we_n && hit;
  assign rd_en = !ce_n && !oe_n && we_n && hit;
endmodule

// File: rtl/rtcw_shadow.sv
`timescale 1ns/1ps
module rtcw_shadow
  import rtcw_pkg::*;
#(
  parameter int NB = TIME_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]      wr_data,
  input  logic            refresh,
  input  logic            hold,
  input  logic [NB*8-1:0] cnt_bytes,
  output logic [NB*8-1:0] uc_bytes
);
  logic [NB*8-1:0] cnt_masked;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    localparam logic [7:0] MASK = keep_mask(gi);
    logic [7:0] byte_q;
    logic [7:0] byte_d;
    logic       sel_wr;

    assign sel_wr = wr_en && (wr_off == OFF_W'(gi));
    assign cnt_masked[gi*8 +: 8] = cnt_bytes[gi*8 +: 8] & MASK;

    always_comb begin
      byte_d = byte_q;
      if (sel_wr)       byte_d = wr_data & MASK;
      else if (refresh) byte_d = cnt_bytes[gi*8 +: 8] & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'h00;
      else        byte_q <= byte_d;
    end

    assign uc_bytes[gi*8 +: 8] = byte_q;
  end

  // R3 / R4: a held copy moves only by host writes
  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(uc_bytes));

  // R2 / R7: a refresh takes every byte in the same cycle
  assert_refresh_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !wr_en) |=> (uc_bytes == $past(cnt_masked)));
endmodule

// File: rtl/rtcw_ctrl.sv
`timescale 1ns/1ps
module rtcw_ctrl
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              sec_wr,
  input  logic              wday_wr,
  input  logic [7:0]        wr_data,
  input  logic              cent_refresh,
  input  logic [CENT_W-1:0] cnt_cent,
  output logic              whold,
  output logic              rhold,
  output logic [CENT_W-1:0] cent,
  output logic              osc_stop,
  output logic              ftest,
  output logic              load
);
  logic              wh_q, wh_d, rh_q, rh_d, osc_q, osc_d, ft_q, ft_d, ld_q, ld_d;
  logic [CENT_W-1:0] cent_q, cent_d;
  logic              sets_hold;

  assign sets_hold = wr_data[BIT_WHOLD] || wr_data[BIT_RHOLD];

  always_comb begin
    wh_d   = wh_q;
    rh_d   = rh_q;
    cent_d = cent_q;
    osc_d  = osc_q;
    ft_d   = ft_q;
    ld_d   = 1'b0;
    if (ctrl_wr) begin
      wh_d = wr_data[BIT_WHOLD];
      rh_d = wr_data[BIT_RHOLD];
      if (!sets_hold && wh_q) cent_d = wr_data[CENT_W-1:0];
      ld_d = wh_q && !wr_data[BIT_WHOLD];
    end else if (cent_refresh) begin
      cent_d = cnt_cent;
    end
    if (sec_wr)  osc_d = wr_data[BIT_OSC];
    if (wday_wr) ft_d  = wr_data[BIT_FTEST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wh_q   <= 1'b0;
      rh_q   <= 1'b0;
      cent_q <= '0;
      osc_q  <= 1'b0;
      ft_q   <= 1'b0;
      ld_q   <= 1'b0;
    end else begin
      wh_q   <= wh_d;
      rh_q   <= rh_d;
      cent_q <= cent_d;
      osc_q  <= osc_d;
      ft_q   <= ft_d;
      ld_q   <= ld_d;
    end
  end

  assign whold    = wh_q;
  assign rhold    = rh_q;
  assign cent     = cent_q;
  assign osc_stop = osc_q;
  assign ftest    = ft_q;
  assign load     = ld_q;

  assert_cent_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && sets_hold) |=> (cent_q == $past(cent_q)));

  assert_cent_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wh_q && !sets_hold) |=> (cent_q == $past(wr_data[CENT_W-1:0])));

  assert_cent_rhclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wh_q) |=> (cent_q == $past(cent_q)));

  assert_load_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |-> (!wh_q && $past(wh_q)));
endmodule

// File: rtl/rtcw_top.sv
`timescale 1ns/1ps
module rtcw_top
  import rtcw_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_ce_n,
  input  logic                      bus_oe_n,
  input  logic                      bus_we_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [7:0]                bus_wdata,
  output logic [7:0]                bus_rdata,
  output logic                      bus_rd_en,
  output logic                      win_hit,
  input  logic [TIME_BYTES*8-1:0]   cnt_time,
  input  logic [CENT_W-1:0]         cnt_century,
  input  logic                      cnt_tick,
  input  logic                      sq512,
  output logic                      load_pulse,
  output logic [TIME_BYTES*8-1:0]   load_time,
  output logic [CENT_W-1:0]         load_century,
  output logic                      osc_run,
  output logic                      ftest_en
);
  localparam int NREG = 1 << OFF_W;

  logic rst_s0, rst_s1, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_int_n = rst_s1;

  logic [OFF_W-1:0] off;
  logic             wr_en, rd_en, hit;

  rtcw_decode #(.ADDR_W(ADDR_W)) u_decode (
    .ce_n (bus_ce_n),
    .oe_n (bus_oe_n),
    .we_n (bus_we_n),
    .addr (bus_addr),
    .hit  (hit),
    .off  (off),
    .wr_en(wr_en),
    .rd_en(rd_en)
  );

  logic              whold, rhold, osc_stop, ftest, load, hold, refresh;
  logic [CENT_W-1:0] cent;
  logic              ctrl_wr, sec_wr, wday_wr, time_wr;

  assign ctrl_wr = wr_en && (off == OFF_CTRL);
  assign sec_wr  = wr_en && (off == OFF_SEC);
  assign wday_wr = wr_en && (off == OFF_WDAY);
  assign time_wr = wr_en && (off != OFF_CTRL);
  assign hold    = whold || rhold;
  assign refresh = cnt_tick && !hold;

  rtcw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ctrl_wr     (ctrl_wr),
    .sec_wr      (sec_wr),
    .wday_wr     (wday_wr),
    .wr_data     (bus_wdata),
    .cent_refresh(refresh),
    .cnt_cent    (cnt_century),
    .whold       (whold),
    .rhold       (rhold),
    .cent        (cent),
    .osc_stop    (osc_stop),
    .ftest       (ftest),
    .load        (load)
  );

  logic [TIME_BYTES*8-1:0] uc_bytes;

  rtcw_shadow #(.NB(TIME_BYTES)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (time_wr),
    .wr_off   (off),
    .wr_data  (bus_wdata),
    .refresh  (refresh),
    .hold     (hold),
    .cnt_bytes(cnt_time),
    .uc_bytes (uc_bytes)
  );

  logic [7:0] view [NREG];
  always_comb begin
    for (int i = 0; i < TIME_BYTES; i++) view[i] = uc_bytes[i*8 +: 8];
    view[OFF_SEC][BIT_OSC]     = osc_stop;
    view[OFF_SEC][0]           = (ftest && !osc_stop) ? sq512 : uc_bytes[0];
    view[OFF_WDAY][BIT_FTEST]  = ftest;
    view[OFF_CTRL]             = {whold, rhold, cent};
  end

  assign bus_rdata    = rd_en ? view[off] : 8'h00;
  assign bus_rd_en    = rd_en;
  assign win_hit      = hit;
  assign load_pulse   = load;
  assign load_time    = uc_bytes;
  assign load_century = cent;
  assign osc_run      = !osc_stop;
  assign ftest_en     = ftest;

  assert_read_in_window_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rd_en |-> win_hit);

  assert_idle_bus_zero_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd_en |-> (bus_rdata == 8'h00));

  assert_ftest_seen_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd_en && (bus_addr[OFF_W-1:0] == OFF_SEC) && ftest_en && osc_run)
      |-> (bus_rdata[0] == sq512));
endmodule

// File: tb/test_rtcw_top.sv
`timescale 1ns/1ps
module test_rtcw_top;
  localparam int AW = 5;
  localparam int NV = 33;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;
  logic          rd_en, hit;
  logic [55:0]   cnt_time;
  logic [5:0]    cnt_century;
  logic          cnt_tick, sq512;
  logic          load_pulse;
  logic [55:0]   load_time;
  logic [5:0]    load_century;
  logic          osc_run, ftest_en;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rtcw_top #(.ADDR_W(AW)) i_rtcw_top (
    .clk(clk), .rst_n(rst_n),
    .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_rd_en(rd_en), .win_hit(hit),
    .cnt_time(cnt_time), .cnt_century(cnt_century), .cnt_tick(cnt_tick),
    .sq512(sq512), .load_pulse(load_pulse), .load_time(load_time),
    .load_century(load_century), .osc_run(osc_run), .ftest_en(ftest_en)
  );

  // fields: req[24:21] kind[20:19] (0 write, 1 read, 2 tick) off[18:16] data[15:8] exp[7:0]
  localparam logic [24:0] VECS [NV] = '{
    {4'd2, 2'd2, 3'd0, 8'h10, 8'h00},  // R2 tick seed 10
    {4'd2, 2'd1, 3'd0, 8'h00, 8'h10},  // R2
    {4'd2, 2'd1, 3'd2, 8'h00, 8'h12},  // R2
    {4'd2, 2'd1, 3'd6, 8'h00, 8'h16},  // R2
    {4'd2, 2'd1, 3'd7, 8'h00, 8'h17},  // R2 century
    {4'd5, 2'd0, 3'd7, 8'h40, 8'h00},  // R5 set read-hold
    {4'd5, 2'd1, 3'd7, 8'h00, 8'h57},  // R5
    {4'd3, 2'd2, 3'd0, 8'h20, 8'h00},  // R3 tick while held
    {4'd3, 2'd1, 3'd1, 8'h00, 8'h11},  // R3
    {4'd3, 2'd1, 3'd7, 8'h00, 8'h57},  // R3
    {4'd6, 2'd0, 3'd7, 8'h05, 8'h00},  // R6 clear read-hold only
    {4'd6, 2'd1, 3'd7, 8'h00, 8'h17},  // R6 century kept
    {4'd7, 2'd1, 3'd1, 8'h00, 8'h11},  // R7 no refresh before tick
    {4'd7, 2'd2, 3'd0, 8'h20, 8'h00},  // R7 tick
    {4'd7, 2'd1, 3'd1, 8'h00, 8'h21},  // R7
    {4'd7, 2'd1, 3'd3, 8'h00, 8'h23},  // R7
    {4'd7, 2'd1, 3'd7, 8'h00, 8'h27},  // R7
    {4'd5, 2'd0, 3'd7, 8'h80, 8'h00},  // R5 set write-hold
    {4'd5, 2'd1, 3'd7, 8'h00, 8'hA7},  // R5
    {4'd4, 2'd0, 3'd1, 8'h45, 8'h00},  // R4 host write
    {4'd4, 2'd0, 3'd5, 8'h09, 8'h00},  // R4
    {4'd4, 2'd1, 3'd1, 8'h00, 8'h45},  // R4
    {4'd4, 2'd2, 3'd0, 8'h30, 8'h00},  // R4 tick ignored
    {4'd4, 2'd1, 3'd1, 8'h00, 8'h45},  // R4
    {4'd4, 2'd1, 3'd5, 8'h00, 8'h09},  // R4
    {4'd6, 2'd0, 3'd7, 8'h19, 8'h00},  // R6 clear write-hold
    {4'd6, 2'd1, 3'd7, 8'h00, 8'h19},  // R6 century loaded
    {4'd2, 2'd2, 3'd0, 8'h30, 8'h00},  // R2 tick
    {4'd2, 2'd1, 3'd1, 8'h00, 8'h31},  // R2
    {4'd5, 2'd0, 3'd7, 8'hC5, 8'h00},  // R5 set both
    {4'd5, 2'd1, 3'd7, 8'h00, 8'hF7},  // R5
    {4'd6, 2'd0, 3'd7, 8'h02, 8'h00},  // R6 clear both with write-hold set
    {4'd6, 2'd1, 3'd7, 8'h00, 8'h02}   // R6
  };

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    addr = {2'b11, off}; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_write_raw(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2;
    d = rdata; en = rd_en;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic tick(input logic [7:0] seed);
    @(negedge clk);
    for (int i = 0; i < 7; i++) cnt_time[i*8 +: 8] = seed + 8'(i);
    cnt_century = 6'(seed + 8'd7);
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic       en;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; wdata = '0; cnt_time = '0; cnt_century = '0; cnt_tick = 1'b0; sq512 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    bus_read({2'b11, 3'd0}, d, en); check("R10", "seconds after reset", d, 8'h00);
    bus_read({2'b11, 3'd7}, d, en); check("R10", "control after reset", d, 8'h00);
    check("R10", "osc_run after reset", osc_run, 1'b1);
    check("R10", "ftest_en after reset", ftest_en, 1'b0);
    check("R10", "load_pulse after reset", load_pulse, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [24:0] row;
      row = VECS[v];
      case (row[20:19])
        2'd0: bus_write(row[18:16], row[15:8]);
        2'd1: begin
          bus_read({2'b11, row[18:16]}, d, en);
          check($sformatf("R%0d", row[24:21]), $sformatf("row %0d", v), d, row[7:0]);
        end
        default: tick(row[15:8]);
      endcase
    end

    // R1 outside the window
    bus_read(5'd3, d, en);
    check("R1", "rd_en outside", en, 1'b0);
    check("R1", "rdata outside", d, 8'h00);
    check("R1", "hit outside", hit, 1'b0);
    bus_write_raw(5'd3, 8'hAA);
    bus_read({2'b11, 3'd1}, d, en);
    check("R1", "minutes after outside write", d, 8'h31);
    check("R1", "rd_en inside", en, 1'b1);

    // R4 load on write-hold clear
    bus_write(3'd7, 8'h80);
    bus_write(3'd0, 8'h33);
    bus_write(3'd6, 8'h59);
    bus_write(3'd7, 8'h05);
    check("R4", "load_pulse high", load_pulse, 1'b1);
    check("R4", "load seconds", load_time[7:0], 8'h33);
    check("R4", "load year", load_time[55:48], 8'h59);
    check("R4", "load century", load_century, 6'h05);
    @(negedge clk);
    check("R4", "load_pulse single", load_pulse, 1'b0);

    // R8 oscillator stop
    bus_write(3'd0, 8'h80);
    check("R8", "osc_run stopped", osc_run, 1'b0);
    bus_read({2'b11, 3'd0}, d, en); check("R8", "seconds readback", d, 8'h80);

    // R9 frequency test
    bus_write(3'd3, 8'h40);
    check("R9", "ftest_en set", ftest_en, 1'b1);
    bus_read({2'b11, 3'd3}, d, en); check("R9", "weekday readback", d, 8'h40);
    sq512 = 1'b1;
    bus_read({2'b11, 3'd0}, d, en); check("R9", "osc stopped lsb", d, 8'h80);
    bus_write(3'd0, 8'h00);
    check("R8", "osc_run restarted", osc_run, 1'b1);
    bus_read({2'b11, 3'd0}, d, en); check("R9", "lsb follows sq high", d, 8'h01);
    sq512 = 1'b0;
    bus_read({2'b11, 3'd0}, d, en); check("R9", "lsb follows sq low", d, 8'h00);

    finish_run();
  end
endmodule